// File: doc/BRIEF.md
# Streaming Level Trigger Detector

This block sits in a 32-bit AXI4-Stream path and acts as the last gate between a two-channel sample source and a DMA write engine. Every beat carries two signed 16-bit samples. The upper half holds channel one and the lower half holds channel two. While the block is idle it holds the path closed. A start pulse arms it, and it then forwards beats unchanged. On each forwarded beat it checks for level crossings and for a manual request.

Software first programs a five-bit enable mask, a packed pair of signed levels, a capture length and a trigger position, and then pulses start last of all. The first accepted beat on which an enabled condition holds is the trigger beat. The block then lets exactly length − position − 1 further beats through, marks the final beat with TLAST and closes the path again. A five-bit record of which enabled conditions held on the trigger beat stays readable until the next start. The position must be smaller than the length.

Top module: `lvl_trig_gate`

## Requirements
- R1: Enable and detected bits are assigned as follows: bit 0 manual, bit 1 channel-one rising, bit 2 channel-one falling, bit 3 channel-two rising, bit 4 channel-two falling. A condition whose enable bit is clear never causes a trigger and never appears in the detected value.
- R2: A rising condition holds on a beat when the signed sample is greater than or equal to its level and the signed previous sample of that channel is below the level.
- R3: A falling condition holds on a beat when the signed sample is less than or equal to its level and the signed previous sample is above the level.
- R4: Channel one is s_tdata[31:16] and channel two is s_tdata[15:0]. In cfg_levels, the channel-one level is in bits 31:16 and the channel-two level is in bits 15:0.
- R5: A start pulse while idle arms the block from the next cycle, and idle stays low until the capture ends. A start while busy is ignored. Mask, levels, length and position are sampled at start, so later changes to them have no effect on the capture in progress.
- R6: After the trigger beat, exactly cfg_len − cfg_pos − 1 further accepted beats pass and the last of them has m_tlast high. If that number is zero, the trigger beat itself has m_tlast high. A stalled downstream does not advance the count.
- R7: The previous-sample history is cleared at start, so the first accepted beat after start never produces a rising or falling condition.
- R8: The detected output is cleared at start. On the trigger beat it takes the set of enabled conditions that held, which may have more than one bit, and it keeps that value until the next start.
- R9: While active, m_tvalid follows s_tvalid, s_tready follows m_tready and m_tdata equals s_tdata. While idle, s_tready and m_tvalid are low.
- R10: A manual_trig pulse while armed with enable bit 0 set makes the current or next accepted beat the trigger beat. A manual pulse while idle, or while bit 0 is clear, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en_mask | input | 5 | Condition enable mask |
| cfg_levels | input | 32 | Packed signed levels, channel one high |
| cfg_len | input | LEN_W | Total capture length in beats |
| cfg_pos | input | LEN_W | Trigger position within the capture |
| start | input | 1 | Arm request, honoured only while idle |
| manual_trig | input | 1 | Manual trigger pulse |
| s_tdata | input | 32 | Upstream sample pair |
| s_tvalid | input | 1 | Upstream valid |
| s_tready | output | 1 | Upstream ready |
| m_tdata | output | 32 | Downstream sample pair |
| m_tvalid | output | 1 | Downstream valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | End of capture frame |
| idle | output | 1 | Block waiting for start |
| armed | output | 1 | Block searching for a trigger |
| detected | output | 5 | Conditions that fired on the trigger beat |

## Verification
A corrupted sample history or a swapped lane shows up as a trigger on the wrong beat. That in turn moves m_tlast and the return of idle, so a per-cycle comparison catches it at the first forwarded beat after the error. A wrong post-trigger count becomes visible only at the end of the frame, as an early or late m_tlast, so the stimulus mixes long and zero-length tails under random backpressure. A stale latched configuration or detected value shows up in the detected port check at the end of each capture.

// File: rtl/lvl_trig_pkg.sv
package lvl_trig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_POST  = 2'd2
  } gate_st_e;

  localparam int NCOND = 5;
  localparam int C_MAN = 0;
  localparam int C_R1  = 1;
  localparam int C_F1  = 2;
  localparam int C_R2  = 3;
  localparam int C_F2  = 4;
  localparam int NCH   = 2;
endpackage

// File: rtl/lvl_cross_det.sv
module lvl_cross_det #(
  parameter int SAMP_W = 16
) (
  input  logic signed [SAMP_W-1:0] cur,
  input  logic signed [SAMP_W-1:0] prev,
  input  logic signed [SAMP_W-1:0] level,
  input  logic                     prev_ok,
  output logic                     rise,
  output logic                     fall
);
  always_comb begin
    rise = prev_ok && (cur >= level) && (prev < level);
    fall = prev_ok && (cur <= level) && (prev > level);
  end
endmodule

// File: rtl/lvl_post_cnt.sv
module lvl_post_cnt #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_l,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             cnt_one
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = load ? load_val : (cnt_q - LEN_W'(1));
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_one = (cnt_q == LEN_W'(1));
endmodule

// File: rtl/lvl_trig_ctrl.sv
module lvl_trig_ctrl
  import lvl_trig_pkg::*;
(
  input  logic     clk,
  input  logic     rst_l,
  input  logic     start,
  input  logic     trig_beat,
  input  logic     remain_zero,
  input  logic     post_last,
  output gate_st_e st
);
  gate_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_ARMED;
      ST_ARMED: if (trig_beat) st_d = remain_zero ? ST_IDLE : ST_POST;
      ST_POST:  if (post_last) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) st_q <= ST_IDLE;
    else st_q <= st_d;
  end

  assign st = st_q;
endmodule

// File: rtl/lvl_trig_gate.sv
module lvl_trig_gate
  import lvl_trig_pkg::*;
#(
  parameter int SAMP_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCOND-1:0]      cfg_en_mask,
  input  logic [2*SAMP_W-1:0]   cfg_levels,
  input  logic [LEN_W-1:0]      cfg_len,
  input  logic [LEN_W-1:0]      cfg_pos,
  input  logic                  start,
  input  logic                  manual_trig,
  input  logic [2*SAMP_W-1:0]   s_tdata,
  input  logic                  s_tvalid,
  output logic                  s_tready,
  output logic [2*SAMP_W-1:0]   m_tdata,
  output logic                  m_tvalid,
  input  logic                  m_tready,
  output logic                  m_tlast,
  output logic                  idle,
  output logic                  armed,
  output logic [NCOND-1:0]      detected
);
  localparam int BEAT_W = 2 * SAMP_W;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  gate_st_e st;
  logic st_armed, st_post, active;
  logic start_ok, beat, trig_beat, post_last, cnt_one, remain_zero;

  logic [NCOND-1:0]  mask_q;
  logic [BEAT_W-1:0] lvl_q;
  logic [LEN_W-1:0]  remain_q, remain_d;
  logic              cfg_en;

  logic [SAMP_W-1:0] prev_q [NCH];
  logic              prev_ok_q, prev_ok_d, prev_en;

  logic              man_pend_q, man_pend_d, man_pend_en, man_hit;
  logic [NCOND-1:0]  det_q, det_d, cond, hit;
  logic              det_en;
  logic [NCH-1:0]    rise_v, fall_v;

  always_comb begin
    st_armed = (st == ST_ARMED);
    st_post  = (st == ST_POST);
    active   = st_armed | st_post;
    start_ok = (st == ST_IDLE) & start;
    beat     = active & s_tvalid & m_tready;
  end

  // configuration captured at start
  always_comb begin
    cfg_en   = start_ok;
    remain_d = cfg_len - cfg_pos - LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      mask_q   <= '0;
      lvl_q    <= '0;
      remain_q <= '0;
    end else if (cfg_en) begin
      mask_q   <= cfg_en_mask;
      lvl_q    <= cfg_levels;
      remain_q <= remain_d;
    end
  end

  // sample history
  always_comb begin
    prev_en   = start_ok | beat;
    prev_ok_d = ~start_ok;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) prev_ok_q <= 1'b0;
    else if (prev_en) prev_ok_q <= prev_ok_d;
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam int LO = (NCH - 1 - g) * SAMP_W;
      logic [SAMP_W-1:0] cur_s, lvl_s;
      assign cur_s = s_tdata[LO +: SAMP_W];
      assign lvl_s = lvl_q[LO +: SAMP_W];

      always_ff @(posedge clk or negedge rst_l) begin
        if (!rst_l) prev_q[g] <= '0;
        else if (beat) prev_q[g] <= cur_s;
      end

      lvl_cross_det #(.SAMP_W(SAMP_W)) u_det (
        .cur     (cur_s),
        .prev    (prev_q[g]),
        .level   (lvl_s),
        .prev_ok (prev_ok_q),
        .rise    (rise_v[g]),
        .fall    (fall_v[g])
      );
    end
  endgenerate

  // manual request, held until a beat takes it
  always_comb begin
    man_hit     = man_pend_q | (manual_trig & mask_q[C_MAN]);
    man_pend_en = start_ok | (st_armed & manual_trig & mask_q[C_MAN] & ~trig_beat);
    man_pend_d  = ~start_ok;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) man_pend_q <= 1'b0;
    else if (man_pend_en) man_pend_q <= man_pend_d;
  end

  always_comb begin
    cond        = '0;
    cond[C_MAN] = man_hit;
    cond[C_R1]  = rise_v[0];
    cond[C_F1]  = fall_v[0];
    cond[C_R2]  = rise_v[1];
    cond[C_F2]  = fall_v[1];
    hit         = cond & mask_q;
    trig_beat   = st_armed & beat & (|hit);
    remain_zero = (remain_q == '0);
    det_en      = start_ok | trig_beat;
    det_d       = start_ok ? '0 : hit;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) det_q <= '0;
    else if (det_en) det_q <= det_d;
  end

  lvl_post_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk      (clk),
    .rst_l    (rst_l),
    .load     (trig_beat),
    .load_val (remain_q),
    .dec      (st_post & beat),
    .cnt_one  (cnt_one)
  );

  assign post_last = st_post & beat & cnt_one;

  lvl_trig_ctrl u_ctrl (
    .clk         (clk),
    .rst_l       (rst_l),
    .start       (start),
    .trig_beat   (trig_beat),
    .remain_zero (remain_zero),
    .post_last   (post_last),
    .st          (st)
  );

  always_comb begin
    s_tready = active & m_tready;
    m_tvalid = active & s_tvalid;
    m_tdata  = s_tdata;
    m_tlast  = m_tvalid & ((st_armed & (|hit) & remain_zero) | (st_post & cnt_one));
    idle     = (st == ST_IDLE);
    armed    = st_armed;
    detected = det_q;
  end
endmodule

// File: rtl/lvl_trig_gate_chk.sv
module lvl_trig_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       idle,
  input logic       armed,
  input logic       st_post,
  input logic       s_tready,
  input logic       m_tvalid,
  input logic       m_tready,
  input logic       m_tlast,
  input logic [4:0] detected,
  input logic [4:0] mask_q
);
  p_idle_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!s_tready && !m_tvalid));

  p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && m_tlast) |=> idle);

  p_start_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |=> (armed && !idle));

  p_det_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !(idle && start)) |=> $stable(detected));

  p_det_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (detected & ~mask_q) == 5'd0);

  p_one_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({idle, armed, st_post}));
endmodule

bind lvl_trig_gate lvl_trig_gate_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .idle     (idle),
  .armed    (armed),
  .st_post  (st_post),
  .s_tready (s_tready),
  .m_tvalid (m_tvalid),
  .m_tready (m_tready),
  .m_tlast  (m_tlast),
  .detected (detected),
  .mask_q   (mask_q)
);

// File: tb/tb_lvl_trig_gate.sv
module tb_lvl_trig_gate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  cfg_en_mask;
  logic [31:0] cfg_levels;
  logic [15:0] cfg_len, cfg_pos;
  logic        start, manual_trig;
  logic [31:0] s_tdata;
  logic        s_tvalid, s_tready;
  logic [31:0] m_tdata;
  logic        m_tvalid, m_tready, m_tlast;
  logic        idle, armed;
  logic [4:0]  detected;

  always #5 clk = ~clk;

  lvl_trig_gate dut (
    .clk(clk), .rst_n(rst_n), .cfg_en_mask(cfg_en_mask), .cfg_levels(cfg_levels),
    .cfg_len(cfg_len), .cfg_pos(cfg_pos), .start(start), .manual_trig(manual_trig),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
    .idle(idle), .armed(armed), .detected(detected)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model state
  int ms = 0;            // 0 idle, 1 armed, 2 post
  int m_mask = 0, m_l1 = 0, m_l2 = 0, m_rem = 0, m_cnt = 0;
  int m_p1 = 0, m_p2 = 0;
  bit m_pok = 0, m_pend = 0;
  int m_det = 0;

  // stimulus knobs
  int d1 = 0, d2 = 0, st1 = 0, st2 = 0, vprob = 100, rprob = 100;
  bit consumed = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cycle(input bit do_start, input bit man);
    int c1, c2, hit, cond;
    bit act, beat, e_last;
    @(negedge clk);
    if (consumed) begin d1 += st1; d2 += st2; end
    s_tdata = {16'(d1), 16'(d2)};
    if (!s_tvalid || consumed) s_tvalid = ($urandom_range(99) < vprob);
    m_tready = ($urandom_range(99) < rprob);
    start = do_start;
    manual_trig = man;
    #1;
    c1 = int'($signed(s_tdata[31:16]));
    c2 = int'($signed(s_tdata[15:0]));
    act = (ms != 0);
    cond = 0;
    if (ms == 1 && (m_pend || (man && m_mask[0]))) cond |= 1;
    if (m_pok && c1 >= m_l1 && m_p1 < m_l1) cond |= 2;
    if (m_pok && c1 <= m_l1 && m_p1 > m_l1) cond |= 4;
    if (m_pok && c2 >= m_l2 && m_p2 < m_l2) cond |= 8;
    if (m_pok && c2 <= m_l2 && m_p2 > m_l2) cond |= 16;
    hit = cond & m_mask;
    e_last = act && s_tvalid && ((ms == 1 && hit != 0 && m_rem == 0) || (ms == 2 && m_cnt == 1));
    chk(m_tvalid == (act && s_tvalid), "R9 m_tvalid", m_tvalid, act && s_tvalid);
    chk(s_tready == (act && m_tready), "R9 s_tready", s_tready, act && m_tready);
    chk(!m_tvalid || m_tdata == s_tdata, "R9 m_tdata", m_tdata, s_tdata);
    chk(m_tlast == e_last, "R6 m_tlast", m_tlast, e_last);
    chk(idle == (ms == 0), "R5 idle", idle, ms == 0);
    chk(armed == (ms == 1), "R5 armed", armed, ms == 1);
    chk(detected == 5'(m_det), "R8 detected", detected, m_det);
    // model step
    beat = act && s_tvalid && m_tready;
    if (ms == 0) begin
      if (do_start) begin
        ms = 1; m_mask = int'(cfg_en_mask);
        m_l1 = int'($signed(cfg_levels[31:16])); m_l2 = int'($signed(cfg_levels[15:0]));
        m_rem = int'(cfg_len) - int'(cfg_pos) - 1;
        m_pok = 0; m_pend = 0; m_det = 0;
      end
    end else if (ms == 1) begin
      if (beat && hit != 0) begin
        m_det = hit;
        if (m_rem == 0) ms = 0; else begin ms = 2; m_cnt = m_rem; end
      end else if (man && m_mask[0]) m_pend = 1;
    end else if (beat) begin
      m_cnt--;
      if (m_cnt == 0) ms = 0;
    end
    if (beat) begin m_p1 = c1; m_p2 = c2; m_pok = 1; end
    consumed = beat;
  endtask

  task automatic run(input int mask, input int l1, input int l2, input int len, input int pos,
                     input int a1, input int s1, input int a2, input int s2,
                     input int vp, input int rp, input int man_at, input bit disturb,
                     input int exp_det, input string tag);
    int n;
    cfg_en_mask = 5'(mask);
    cfg_levels = {16'(l1), 16'(l2)};
    cfg_len = 16'(len); cfg_pos = 16'(pos);
    d1 = a1; d2 = a2; st1 = s1; st2 = s2; vprob = vp; rprob = rp;
    cycle(1'b1, 1'b0);
    n = 0;
    while (ms != 0 && n < 3000) begin
      if (disturb && n == 1) begin
        cfg_en_mask = ~5'(mask); cfg_len = 16'd2; cfg_pos = 16'd0; cfg_levels = 32'h0;
      end
      cycle(disturb && n == 2, n == man_at);
      n++;
    end
    chk(ms == 0, {tag, " capture finished"}, n, 0);
    cycle(1'b0, 1'b0);
    chk(detected == 5'(exp_det), {tag, " detected value"}, detected, exp_det);
    chk(idle == 1'b1, "R5 idle after capture", idle, 1);
  endtask

  initial begin
    rst_n = 1'b0; start = 0; manual_trig = 0; s_tvalid = 0; s_tdata = 0; m_tready = 0;
    cfg_en_mask = 0; cfg_levels = 0; cfg_len = 0; cfg_pos = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(idle && !s_tready && !m_tvalid && detected == 0, "R9 reset state", {idle, s_tready, m_tvalid, detected}, 8'h80);
    // manual pulse while idle is ignored (R10)
    cycle(1'b0, 1'b1);
    // R2 channel-one rising at level 0
    run(5'b00010, 0, 16'h7000, 16, 4, -20, 3, 0, 0, 80, 100, -1, 0, 5'b00010, "R2 ch1 rise");
    // R3 channel-one falling, negative level
    run(5'b00100, -50, 0, 12, 3, 40, -7, 0, 0, 90, 100, -1, 0, 5'b00100, "R3 ch1 fall");
    // R7 stale history below level, first beat at 5 must not fire; manual ends it
    run(5'b00011, 0, 0, 6, 2, 5, 0, 0, 0, 100, 100, 20, 0, 5'b00001, "R7 no stale trigger");
    // R1 R4 ch2 rising on equality, ch1 crossing masked
    run(5'b01000, 0, 100, 10, 2, -10, 5, 0, 10, 75, 90, -1, 0, 5'b01000, "R1 R4 ch2 rise masked ch1");
    // R3 ch2 falling under backpressure
    run(5'b10000, 0, -1000, 20, 5, 0, 0, 0, -300, 70, 50, -1, 0, 5'b10000, "R3 ch2 fall");
    // R10 manual with bit set
    run(5'b00001, 0, 0, 9, 4, 7, 0, 7, 0, 60, 80, 5, 0, 5'b00001, "R10 manual");
    // R10 manual with bit clear ignored, rising fires instead
    run(5'b00010, 0, 0, 8, 2, -30, 2, 0, 0, 100, 100, 2, 0, 5'b00010, "R10 manual masked");
    // R6 zero-length tail: trigger beat carries last
    run(5'b00010, 0, 0, 8, 7, -4, 2, 0, 0, 100, 100, -1, 0, 5'b00010, "R6 last on trigger");
    // R8 both channels on the same beat
    run(5'b01010, 0, 0, 5, 1, -6, 2, -6, 2, 85, 85, -1, 0, 5'b01010, "R8 two conditions");
    // R5 start while busy and config change ignored
    run(5'b00010, 0, 0, 14, 3, -40, 4, 0, 0, 100, 100, -1, 1, 5'b00010, "R5 busy start");
    // R6 long tail stalled by downstream
    run(5'b00100, 0, 0, 40, 0, 9, -3, 0, 0, 90, 30, -1, 0, 5'b00100, "R6 stalled tail");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule